// File: doc/BRIEF.md
# Three-Wire Serial Register Interface

This block is a write-only serial slave that loads a small bank of control registers from three wires: a serial clock, a serial data line and an active-low load strobe. All three inputs are resynchronised into the register clock domain. Each frame carries a 3-bit register address, one test bit and then 12-bit data words, every field least significant bit first. While the strobe stays low, each additional 12-bit word goes to the next register address.

Received words are held in staging registers. They reach the live registers only when the strobe rises, so the controlled logic never sees a half-written set of values. Committing an operation word with its software-reset bit set returns every register to its default. For a parameterised number of clock cycles after reset, a power-on period is in force, and any frame that starts during it is ignored.

The framing state machine has five states. IDLE means the strobe is high. ADDR collects three address bits. TEST takes the test bit. DATA collects data words. DROP discards bits until the strobe rises. The transitions are:
- strobe fall: IDLE to ADDR, only when the power-on period is over.
- third address bit: ADDR to TEST.
- test bit 0 with an address in range: TEST to DATA.
- test bit 1, or an address out of range: TEST to DROP.
- a completed word at the last address: DATA to DROP.
- a completed word below the last address: DATA stays in DATA and the address increments.
- strobe rise: any state to IDLE, with a commit unless the state was already IDLE.
- power-on period active: forced to IDLE.

Top module: `ser_reg_if`

## Requirements
- R1: A bit is taken on each serial-clock rising edge only while the load strobe is low. Clock edges seen while the strobe is high shift nothing, and the next frame decodes normally.
- R2: A frame sends three address bits A0 first, one test bit, then data bits D0 first. The register addresses are: 0 operation (12 bits), 1 control (12 bits), 2 clamp level, 3 gain.
- R3: A completed word leaves the live registers unchanged until the load strobe rises, and then appears on the outputs.
- R4: With the strobe held low, each further 12-bit word is written to the next higher address.
- R5: Words aimed past address 3 are dropped. Frames whose address is 4 to 7 are dropped. Frames whose test bit is 1 are dropped. In all three cases the registers are unchanged.
- R6: A word cut short by a strobe rise is discarded. Complete words earlier in the same frame still commit.
- R7: After reset the operation, control and gain registers read 0 and the clamp level reads 128.
- R8: Committing an operation word with bit 0 set restores every register to its reset value.
- R9: Operation bits 2:1 decode power mode. 01 raises the standby output, 10 raises the shutdown output, and 00 or 11 raises neither.
- R10: A frame whose strobe falls during the first POR_CYCLES clocks after reset changes no register.
- R11: The clamp level takes data bits 7:0 and the gain takes data bits 9:0. Higher data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| ser_load | input | 1 | Load strobe, low during a frame; rising edge commits |
| oper_word | output | DATA_W | Live operation register |
| ctrl_word | output | DATA_W | Live control register |
| clamp_lvl | output | CLAMP_W | Live clamp level |
| gain_code | output | GAIN_W | Live gain code |
| pwr_standby | output | 1 | Power mode 01 decoded |
| pwr_off | output | 1 | Power mode 10 decoded |

## Verification
The assertions assume that the serial inputs change slowly enough for the synchroniser to see every level. Each serial-clock phase must last several register clocks. The strobe must not rise on the same register clock as a serial-clock edge. The bench holds each serial phase for four register clocks and changes data only while the serial clock is low. It moves the strobe half a serial period away from any clock edge, so every edge reaches the framing logic as a separate, ordered event.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_TEST,
        ST_DATA,
        ST_DROP
    } frame_state_t;

    localparam int REG_OPER     = 0;
    localparam int REG_CTRL     = 1;
    localparam int REG_CLAMP    = 2;
    localparam int REG_GAIN     = 3;

    localparam int SOFT_RST_BIT = 0;
    localparam int PWR_LSB      = 1;
    localparam logic [1:0] PWR_STANDBY = 2'b01;
    localparam logic [1:0] PWR_OFF     = 2'b10;

endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/ser_por_timer.sv
module ser_por_timer #(
    parameter int CYCLES = 25000
) (
    input  logic clk,
    input  logic rst_n,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign busy = (cnt_q != LIMIT);

endmodule

// File: rtl/ser_frame_fsm.sv
module ser_frame_fsm
    import ser_reg_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 12,
    parameter int NUM_REGS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              sck_s,
    input  logic              sdat_s,
    input  logic              ld_s,
    output logic              word_valid,
    output logic [ADDR_W-1:0] word_addr,
    output logic [DATA_W-1:0] word_data,
    output logic              commit,
    output logic              fsm_idle
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  ADDR_LAST_BIT = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0]  DATA_LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR     = ADDR_W'(NUM_REGS - 1);

    frame_state_t      state_q, state_nx;
    logic [CNT_W-1:0]  cnt_q, cnt_nx;
    logic [ADDR_W-1:0] addr_q, addr_nx;
    logic [DATA_W-2:0] data_q, data_nx;
    logic              sck_prev_q, ld_prev_q;
    logic              sck_rise, ld_rise, ld_fall;

    assign sck_rise = sck_s & ~sck_prev_q;
    assign ld_rise  = ld_s & ~ld_prev_q;
    assign ld_fall  = ~ld_s & ld_prev_q;

    // next-state logic
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        addr_nx  = addr_q;
        data_nx  = data_q;
        if (busy || ld_rise) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ld_fall) begin
                        state_nx = ST_ADDR;
                        cnt_nx   = '0;
                    end
                end
                ST_ADDR: begin
                    if (sck_rise) begin
                        addr_nx = {sdat_s, addr_q[ADDR_W-1:1]};
                        if (cnt_q == ADDR_LAST_BIT) begin
                            state_nx = ST_TEST;
                            cnt_nx   = '0;
                        end else begin
                            cnt_nx = cnt_q + 1'b1;
                        end
                    end
                end
                ST_TEST: begin
                    if (sck_rise) begin
                        if (sdat_s || (addr_q > LAST_ADDR)) state_nx = ST_DROP;
                        else                                state_nx = ST_DATA;
                        cnt_nx = '0;
                    end
                end
                ST_DATA: begin
                    if (sck_rise) begin
                        data_nx = {sdat_s, data_q[DATA_W-2:1]};
                        if (cnt_q == DATA_LAST_BIT) begin
                            cnt_nx = '0;
                            if (addr_q == LAST_ADDR) state_nx = ST_DROP;
                            else                     addr_nx  = addr_q + 1'b1;
                        end else begin
                            cnt_nx = cnt_q + 1'b1;
                        end
                    end
                end
                ST_DROP: state_nx = ST_DROP;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            addr_q     <= '0;
            data_q     <= '0;
            sck_prev_q <= 1'b0;
            ld_prev_q  <= 1'b1;
        end else begin
            state_q    <= state_nx;
            cnt_q      <= cnt_nx;
            addr_q     <= addr_nx;
            data_q     <= data_nx;
            sck_prev_q <= sck_s;
            ld_prev_q  <= ld_s;
        end
    end

    // outputs
    always_comb begin
        word_valid = (state_q == ST_DATA) && sck_rise && !ld_rise && !busy
                     && (cnt_q == DATA_LAST_BIT);
        word_addr  = addr_q;
        word_data  = {sdat_s, data_q};
        commit     = ld_rise && (state_q != ST_IDLE) && !busy;
        fsm_idle   = (state_q == ST_IDLE);
    end

endmodule

// File: rtl/ser_reg_bank.sv
module ser_reg_bank
    import ser_reg_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 12,
    parameter int NUM_REGS = 4,
    parameter int CLAMP_W  = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             word_valid,
    input  logic [ADDR_W-1:0]                word_addr,
    input  logic [DATA_W-1:0]                word_data,
    input  logic                             commit,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  live_q
);

    localparam logic [DATA_W-1:0] CLAMP_DFLT = DATA_W'(1) << (CLAMP_W - 1);

    function automatic logic [DATA_W-1:0] dflt_of(int idx);
        return (idx == REG_CLAMP) ? CLAMP_DFLT : '0;
    endfunction

    logic [NUM_REGS-1:0][DATA_W-1:0] stage_q;
    logic [NUM_REGS-1:0]             pend_q;
    logic                            soft_rst;

    assign soft_rst = pend_q[REG_OPER] && stage_q[REG_OPER][SOFT_RST_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                stage_q[i] <= '0;
                live_q[i]  <= dflt_of(i);
            end
            pend_q <= '0;
        end else if (commit) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (soft_rst)       live_q[i] <= dflt_of(i);
                else if (pend_q[i]) live_q[i] <= stage_q[i];
            end
            pend_q <= '0;
        end else if (word_valid) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (word_addr == ADDR_W'(i)) begin
                    stage_q[i] <= word_data;
                    pend_q[i]  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ser_reg_if.sv
module ser_reg_if
    import ser_reg_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 12,
    parameter int NUM_REGS    = 4,
    parameter int CLAMP_W     = 8,
    parameter int GAIN_W      = 10,
    parameter int SYNC_STAGES = 2,
    parameter int POR_CYCLES  = 25000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               ser_load,
    output logic [DATA_W-1:0]  oper_word,
    output logic [DATA_W-1:0]  ctrl_word,
    output logic [CLAMP_W-1:0] clamp_lvl,
    output logic [GAIN_W-1:0]  gain_code,
    output logic               pwr_standby,
    output logic               pwr_off
);

    logic [2:0]                      sync_q;
    logic                            por_busy;
    logic                            word_valid;
    logic [ADDR_W-1:0]               word_addr;
    logic [DATA_W-1:0]               word_data;
    logic                            commit;
    logic                            fsm_idle;
    logic [NUM_REGS-1:0][DATA_W-1:0] live_q;
    logic [1:0]                      pwr_field;

    ser_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_load, ser_dat, ser_clk}),
        .q     (sync_q)
    );

    ser_por_timer #(
        .CYCLES (POR_CYCLES)
    ) u_por (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (por_busy)
    );

    ser_frame_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (por_busy),
        .sck_s      (sync_q[0]),
        .sdat_s     (sync_q[1]),
        .ld_s       (sync_q[2]),
        .word_valid (word_valid),
        .word_addr  (word_addr),
        .word_data  (word_data),
        .commit     (commit),
        .fsm_idle   (fsm_idle)
    );

    ser_reg_bank #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .CLAMP_W  (CLAMP_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_addr  (word_addr),
        .word_data  (word_data),
        .commit     (commit),
        .live_q     (live_q)
    );

    assign oper_word   = live_q[REG_OPER];
    assign ctrl_word   = live_q[REG_CTRL];
    assign clamp_lvl   = live_q[REG_CLAMP][CLAMP_W-1:0];
    assign gain_code   = live_q[REG_GAIN][GAIN_W-1:0];
    assign pwr_field   = oper_word[PWR_LSB +: 2];
    assign pwr_standby = (pwr_field == PWR_STANDBY);
    assign pwr_off     = (pwr_field == PWR_OFF);

endmodule

// File: rtl/ser_reg_chk.sv
module ser_reg_chk #(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 12,
    parameter int NUM_REGS = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            por_busy,
    input logic                            fsm_idle,
    input logic                            word_valid,
    input logic [ADDR_W-1:0]               word_addr,
    input logic                            commit,
    input logic [NUM_REGS-1:0][DATA_W-1:0] live
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

    p_hold_until_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(live));

    p_word_or_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({word_valid, commit}) <= 1);

    p_addr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (word_addr <= LAST_ADDR));

    p_por_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        por_busy |-> (fsm_idle && !word_valid && !commit));

    p_por_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !por_busy |=> !por_busy);

endmodule

bind ser_reg_if ser_reg_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_busy   (por_busy),
    .fsm_idle   (fsm_idle),
    .word_valid (word_valid),
    .word_addr  (word_addr),
    .commit     (commit),
    .live       (live_q)
);

// File: tb/test_ser_reg_if.sv
`timescale 1ns/1ps
module test_ser_reg_if;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_load = 1'b1;
    logic [11:0] oper_word, ctrl_word;
    logic [7:0]  clamp_lvl;
    logic [9:0]  gain_code;
    logic        pwr_standby, pwr_off;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    ser_reg_if #(.POR_CYCLES(40)) i_ser_reg_if (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_load(ser_load), .oper_word(oper_word), .ctrl_word(ctrl_word),
        .clamp_lvl(clamp_lvl), .gain_code(gain_code),
        .pwr_standby(pwr_standby), .pwr_off(pwr_off)
    );

    typedef struct packed {
        logic [2:0]  a;
        logic [11:0] d;
        logic [11:0] eo;
        logic [11:0] ec;
        logic [7:0]  ecl;
        logic [9:0]  eg;
        logic        es;
        logic        ex;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd3, 12'h2A5, 12'h000, 12'h000, 8'h80, 10'h2A5, 1'b0, 1'b0}, // R2 gain
        '{3'd2, 12'hF3C, 12'h000, 12'h000, 8'h3C, 10'h2A5, 1'b0, 1'b0}, // R11 clamp
        '{3'd1, 12'h055, 12'h000, 12'h055, 8'h3C, 10'h2A5, 1'b0, 1'b0}, // R2 ctrl
        '{3'd0, 12'h004, 12'h004, 12'h055, 8'h3C, 10'h2A5, 1'b0, 1'b1}, // R9 off
        '{3'd3, 12'hFFF, 12'h004, 12'h055, 8'h3C, 10'h3FF, 1'b0, 1'b1}, // R11 gain
        '{3'd0, 12'h002, 12'h002, 12'h055, 8'h3C, 10'h3FF, 1'b1, 1'b0}  // R9 standby
    };

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(string req, logic [11:0] eo, logic [11:0] ec,
                             logic [7:0] ecl, logic [9:0] eg, logic es, logic ex);
        chk({req, " oper"},  oper_word, eo);
        chk({req, " ctrl"},  ctrl_word, ec);
        chk({req, " clamp"}, {4'h0, clamp_lvl}, {4'h0, ecl});
        chk({req, " gain"},  {2'b0, gain_code}, {2'b0, eg});
        chk({req, " stby"},  {11'h0, pwr_standby}, {11'h0, es});
        chk({req, " off"},   {11'h0, pwr_off}, {11'h0, ex});
    endtask

    task automatic send_bit(logic b);
        ser_dat = b;
        tick(HALF);
        ser_clk = 1'b1;
        tick(HALF);
        ser_clk = 1'b0;
    endtask

    task automatic frame_start();
        ser_load = 1'b0;
        tick(HALF);
    endtask

    task automatic frame_end();
        tick(HALF);
        ser_load = 1'b1;
        tick(12);
    endtask

    task automatic send_head(logic [2:0] a, logic t);
        for (int i = 0; i < 3; i++) send_bit(a[i]);
        send_bit(t);
    endtask

    task automatic send_word(logic [11:0] d, int nbits);
        for (int i = 0; i < nbits; i++) send_bit(d[i]);
    endtask

    task automatic write1(logic [2:0] a, logic [11:0] d);
        frame_start();
        send_head(a, 1'b0);
        send_word(d, 12);
        frame_end();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(3);
        check_all("R7 reset", 12'h000, 12'h000, 8'h80, 10'h000, 1'b0, 1'b0);
        tick(2);
        rst_n = 1'b1;
        // R10: frame started inside the power-on window is ignored
        write1(3'd3, 12'h3AB);
        check_all("R10 por", 12'h000, 12'h000, 8'h80, 10'h000, 1'b0, 1'b0);
        tick(60);

        for (int i = 0; i < 6; i++) begin
            write1(VECS[i].a, VECS[i].d);
            check_all("R2 table", VECS[i].eo, VECS[i].ec, VECS[i].ecl,
                      VECS[i].eg, VECS[i].es, VECS[i].ex);
        end

        // R9: mode 11 raises neither flag
        write1(3'd0, 12'h006);
        check_all("R9 mode11", 12'h006, 12'h055, 8'h3C, 10'h3FF, 1'b0, 1'b0);

        // R3: no change before strobe rises
        frame_start();
        send_head(3'd3, 1'b0);
        send_word(12'h123, 12);
        tick(12);
        chk("R3 staged", {2'b0, gain_code}, 12'h3FF);
        frame_end();
        chk("R3 commit", {2'b0, gain_code}, 12'h123);

        // R4 / R5: burst from clamp; third word past address 3 dropped
        frame_start();
        send_head(3'd2, 1'b0);
        send_word(12'h011, 12);
        send_word(12'h155, 12);
        send_word(12'hABC, 12);
        frame_end();
        check_all("R4 burst", 12'h006, 12'h055, 8'h11, 10'h155, 1'b0, 1'b0);

        // R5: out-of-range address and test bit set
        write1(3'd5, 12'hFFF);
        check_all("R5 addr5", 12'h006, 12'h055, 8'h11, 10'h155, 1'b0, 1'b0);
        frame_start();
        send_head(3'd3, 1'b1);
        send_word(12'h000, 12);
        frame_end();
        check_all("R5 test1", 12'h006, 12'h055, 8'h11, 10'h155, 1'b0, 1'b0);

        // R6: partial second word discarded
        frame_start();
        send_head(3'd1, 1'b0);
        send_word(12'h0A0, 12);
        send_word(12'h0FF, 5);
        frame_end();
        check_all("R6 partial", 12'h006, 12'h0A0, 8'h11, 10'h155, 1'b0, 1'b0);

        // R1: clocks with strobe high shift nothing
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        tick(12);
        check_all("R1 idle", 12'h006, 12'h0A0, 8'h11, 10'h155, 1'b0, 1'b0);
        write1(3'd1, 12'h123);
        check_all("R1 after", 12'h006, 12'h123, 8'h11, 10'h155, 1'b0, 1'b0);

        // R8: soft reset
        write1(3'd0, 12'h001);
        check_all("R8 soft", 12'h000, 12'h000, 8'h80, 10'h000, 1'b0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule